// File: doc/BRIEF.md
# Coherence Incoming Event Classifier

This block sits in front of a private cache's coherence controller and turns raw inbound messages into one controller event per cycle. It watches three inbound queues: responses arriving from the outer cache level, requests forwarded down from the outer level, and requests or invalidation replies coming up from the inner cache. Each queue head carries a message type, a line index and the lookup results for that line. Those results come from a line state store outside this block.

Each cycle the block picks the highest-priority queue whose head is valid and not parked. It decodes that message against the current line state, the outstanding acknowledgement count and whether the sender is a peer cache, and presents an event code, a line index and an error flag to the downstream controller. The block never removes a message on its own. It raises a consume strobe for the chosen queue only when the controller accepts the event without stalling it. If the controller stalls the event, that queue is parked on the event's line index until a wake-up for that same index arrives, and lower-priority queues proceed in the meantime.

When an inner-cache request misses and the set has no free way, the block reports a replacement event on the victim line instead of the request.

Top module: `coh_event_classifier`

## Requirements
- R1: After reset no queue is parked. With no queue valid, `ev_vld` and all three consume strobes are 0.
- R2: Among eligible queues (valid and not parked), the outer response queue wins over the forwarded-request queue, which wins over the inner queue. `ev_idx` is the chosen queue's line index, except as stated in R8.
- R3: Response decoding uses type codes 0 data, 1 exclusive data, 2 ack and 3 writeback ack. Exclusive data gives event 11. Plain data gives event 12 when the line state is 8 or 11 and `rsp_peer` is 1.
- R4: Other plain data gives event 13 when `rsp_pend - rsp_acks` (modulo 2^ACKW) is zero, and event 10 otherwise. An ack gives event 16 when the same difference is zero, and event 15 otherwise.
- R5: A writeback ack gives event 17. Response type codes 4 to 7 give event 31 with `ev_err` set. `ev_err` is 0 for every other event.
- R6: A forwarded request (type codes 0 invalidate, 1 exclusive read, 2 upgrade, 3 shared read) whose line state is one of 2, 4, 6, 14, 15, 16 or 18 (held by the inner cache) gives event 6. Otherwise it gives 4, 8, 8 or 9 for those type codes in that order.
- R7: Inner types 0 (invalidate with data) and 1 (invalidate ack) give events 3 and 14. When `inr_hit` or `inr_way_free` is 1, inner types 2 (shared read), 3 (exclusive read), 4 (upgrade) and 5 (writeback) give 0, 1, 1 and 2. Inner types 6 and 7 give event 31 with `ev_err` set.
- R8: An inner request of type 2 to 5 with `inr_hit` and `inr_way_free` both 0 reports on `vic_idx`. It gives event 5 when `vic_state` is held by the inner cache (the R6 set), and event 7 otherwise.
- R9: At most one consume strobe is high in a cycle. It is the chosen queue's strobe, and it is high only when `ctl_accept` is 1 and `ctl_stall` is 0.
- R10: An event that is accepted with `ctl_stall` high parks its queue on `ev_idx` from the next cycle. A parked queue is skipped until `wake_vld` arrives with a matching `wake_idx`. A wake-up with any other index has no effect. When a queue parks and a wake-up arrives in the same cycle, the queue still parks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_vld | input | 1 | Outer response queue head valid |
| rsp_type | input | 3 | Response type code |
| rsp_idx | input | IDXW | Response line index |
| rsp_state | input | 5 | Current state of the response's line |
| rsp_peer | input | 1 | Response sender is a peer private cache |
| rsp_acks | input | ACKW | Ack count carried by the response |
| rsp_pend | input | ACKW | Outstanding ack count for the line |
| rsp_pop | output | 1 | Consume strobe for the response queue |
| fwd_vld | input | 1 | Forwarded-request queue head valid |
| fwd_type | input | 2 | Forwarded request type code |
| fwd_idx | input | IDXW | Forwarded request line index |
| fwd_state | input | 5 | Current state of the forwarded request's line |
| fwd_pop | output | 1 | Consume strobe for the forwarded-request queue |
| inr_vld | input | 1 | Inner queue head valid |
| inr_type | input | 3 | Inner message type code |
| inr_idx | input | IDXW | Inner message line index |
| inr_hit | input | 1 | Inner message's line is present |
| inr_way_free | input | 1 | Target set has a free way |
| vic_idx | input | IDXW | Victim line index for the target set |
| vic_state | input | 5 | Victim line state |
| inr_pop | output | 1 | Consume strobe for the inner queue |
| ctl_accept | input | 1 | Controller takes the presented event |
| ctl_stall | input | 1 | Controller stalls the presented event |
| wake_vld | input | 1 | Wake-up pulse valid |
| wake_idx | input | IDXW | Line index being woken |
| ev_vld | output | 1 | Event presented |
| ev_code | output | 5 | Event code |
| ev_idx | output | IDXW | Line index the event applies to |
| ev_err | output | 1 | Message type not decodable |

## Verification
The event outputs and consume strobes are combinational, so each is due in the same cycle its queue heads and controller handshake are driven. The bench drives inputs just after the falling edge and samples one time step later, well before the rising edge. Parking and wake-up act through a register, so their effect is due from the first cycle after the rising edge that captured them. The bench's queue-parking model updates only after that cycle's comparison, which keeps its expectations aligned with that one-edge delay. Random traffic uses few line indices and small ack counts, so that wake-ups match and the ack difference often reaches zero.

// File: rtl/coh_event_classifier.sv
module coh_event_classifier #(
  parameter int IDXW = 6,
  parameter int ACKW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rsp_vld,
  input  logic [2:0]      rsp_type,
  input  logic [IDXW-1:0] rsp_idx,
  input  logic [4:0]      rsp_state,
  input  logic            rsp_peer,
  input  logic [ACKW-1:0] rsp_acks,
  input  logic [ACKW-1:0] rsp_pend,
  output logic            rsp_pop,
  input  logic            fwd_vld,
  input  logic [1:0]      fwd_type,
  input  logic [IDXW-1:0] fwd_idx,
  input  logic [4:0]      fwd_state,
  output logic            fwd_pop,
  input  logic            inr_vld,
  input  logic [2:0]      inr_type,
  input  logic [IDXW-1:0] inr_idx,
  input  logic            inr_hit,
  input  logic            inr_way_free,
  input  logic [IDXW-1:0] vic_idx,
  input  logic [4:0]      vic_state,
  output logic            inr_pop,
  input  logic            ctl_accept,
  input  logic            ctl_stall,
  input  logic            wake_vld,
  input  logic [IDXW-1:0] wake_idx,
  output logic            ev_vld,
  output logic [4:0]      ev_code,
  output logic [IDXW-1:0] ev_idx,
  output logic            ev_err
);
  localparam logic [4:0] EV_LOAD = 5'd0, EV_STORE = 5'd1, EV_WBACK = 5'd2, EV_IN_DATA = 5'd3,
                         EV_INV = 5'd4, EV_INV_SELF = 5'd5, EV_INV_OTHER = 5'd6, EV_EVICT = 5'd7,
                         EV_FWD_X = 5'd8, EV_FWD_S = 5'd9, EV_DATA = 5'd10, EV_DATA_EX = 5'd11,
                         EV_DATA_PEER = 5'd12, EV_DATA_ALL = 5'd13, EV_IN_ACK = 5'd14,
                         EV_ACK = 5'd15, EV_ACK_ALL = 5'd16, EV_WB_DONE = 5'd17, EV_ERR = 5'd31;
  localparam logic [4:0] ST_RD_WAIT = 5'd8, ST_RD_WAIT_INV = 5'd11;

  function automatic logic held_inward(input logic [4:0] st);
    return st inside {5'd2, 5'd4, 5'd6, 5'd14, 5'd15, 5'd16, 5'd18};
  endfunction

  logic [2:0]            parked;
  logic [2:0][IDXW-1:0]  park_idx;
  logic [2:0]            elig, sel;
  logic [ACKW-1:0]       ack_left;
  logic [4:0]            c_rsp, c_fwd, c_inr;
  logic                  e_rsp, e_inr;
  logic [IDXW-1:0]       i_inr;
  logic                  go;

  assign elig = {inr_vld & ~parked[2], fwd_vld & ~parked[1], rsp_vld & ~parked[0]};
  assign sel  = {elig[2] & ~|elig[1:0], elig[1] & ~elig[0], elig[0]};
  assign ack_left = rsp_pend - rsp_acks;

  always_comb begin
    e_rsp = 1'b0;
    c_rsp = EV_ERR;
    case (rsp_type)
      3'd0: begin
        if ((rsp_state == ST_RD_WAIT || rsp_state == ST_RD_WAIT_INV) && rsp_peer) c_rsp = EV_DATA_PEER;
        else c_rsp = (ack_left == '0) ? EV_DATA_ALL : EV_DATA;
      end
      3'd1: c_rsp = EV_DATA_EX;
      3'd2: c_rsp = (ack_left == '0) ? EV_ACK_ALL : EV_ACK;
      3'd3: c_rsp = EV_WB_DONE;
      default: e_rsp = 1'b1;
    endcase
  end

  always_comb begin
    if (held_inward(fwd_state)) c_fwd = EV_INV_OTHER;
    else begin
      case (fwd_type)
        2'd0:    c_fwd = EV_INV;
        2'd3:    c_fwd = EV_FWD_S;
        default: c_fwd = EV_FWD_X;
      endcase
    end
  end

  always_comb begin
    e_inr = 1'b0;
    i_inr = inr_idx;
    c_inr = EV_ERR;
    case (inr_type)
      3'd0: c_inr = EV_IN_DATA;
      3'd1: c_inr = EV_IN_ACK;
      3'd2, 3'd3, 3'd4, 3'd5: begin
        if (!inr_hit && !inr_way_free) begin
          i_inr = vic_idx;
          c_inr = held_inward(vic_state) ? EV_INV_SELF : EV_EVICT;
        end else if (inr_type == 3'd2) c_inr = EV_LOAD;
        else if (inr_type == 3'd5)     c_inr = EV_WBACK;
        else                           c_inr = EV_STORE;
      end
      default: e_inr = 1'b1;
    endcase
  end

  assign ev_vld  = |elig;
  assign ev_code = sel[0] ? c_rsp : sel[1] ? c_fwd : c_inr;
  assign ev_idx  = sel[0] ? rsp_idx : sel[1] ? fwd_idx : i_inr;
  assign ev_err  = (sel[0] & e_rsp) | (sel[2] & e_inr);

  assign go = ev_vld & ctl_accept;
  assign {inr_pop, fwd_pop, rsp_pop} = sel & {3{go & ~ctl_stall}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parked   <= '0;
      park_idx <= '0;
    end else begin
      for (int q = 0; q < 3; q++) begin
        if (go && sel[q] && ctl_stall) begin
          parked[q]   <= 1'b1;
          park_idx[q] <= ev_idx;
        end else if (wake_vld && wake_idx == park_idx[q]) begin
          parked[q] <= 1'b0;
        end
      end
    end
  end

  p_single_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inr_pop, fwd_pop, rsp_pop}));
  p_pop_handshake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_pop || fwd_pop || inr_pop) |-> (ev_vld && ctl_accept && !ctl_stall));
  p_rsp_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !parked[0]) |-> (!fwd_pop && !inr_pop));
  p_park_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[0] && ctl_accept && ctl_stall) |=> !rsp_pop);
  p_park_inr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2] && ctl_accept && ctl_stall) |=> !inr_pop);
  p_err_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> (ev_code == EV_ERR));
endmodule

// File: tb/coh_event_classifier_bench.sv
module coh_event_classifier_bench;
  localparam int IDXW = 6;
  localparam int ACKW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsp_vld = 0, rsp_peer = 0, fwd_vld = 0, inr_vld = 0, inr_hit = 0, inr_way_free = 0;
  logic ctl_accept = 0, ctl_stall = 0, wake_vld = 0;
  logic [2:0] rsp_type = 0, inr_type = 0;
  logic [1:0] fwd_type = 0;
  logic [IDXW-1:0] rsp_idx = 0, fwd_idx = 0, inr_idx = 0, vic_idx = 0, wake_idx = 0;
  logic [4:0] rsp_state = 0, fwd_state = 0, vic_state = 0;
  logic [ACKW-1:0] rsp_acks = 0, rsp_pend = 0;
  logic rsp_pop, fwd_pop, inr_pop, ev_vld, ev_err;
  logic [4:0] ev_code;
  logic [IDXW-1:0] ev_idx;

  int total = 0, bad = 0;
  bit done = 0;
  logic [2:0] m_park = 0;
  logic [IDXW-1:0] m_pidx [3];

  always #5 clk = ~clk;

  coh_event_classifier #(.IDXW(IDXW), .ACKW(ACKW)) u_coh_event_classifier (
    .clk(clk), .rst_n(rst_n),
    .rsp_vld(rsp_vld), .rsp_type(rsp_type), .rsp_idx(rsp_idx), .rsp_state(rsp_state),
    .rsp_peer(rsp_peer), .rsp_acks(rsp_acks), .rsp_pend(rsp_pend), .rsp_pop(rsp_pop),
    .fwd_vld(fwd_vld), .fwd_type(fwd_type), .fwd_idx(fwd_idx), .fwd_state(fwd_state), .fwd_pop(fwd_pop),
    .inr_vld(inr_vld), .inr_type(inr_type), .inr_idx(inr_idx), .inr_hit(inr_hit),
    .inr_way_free(inr_way_free), .vic_idx(vic_idx), .vic_state(vic_state), .inr_pop(inr_pop),
    .ctl_accept(ctl_accept), .ctl_stall(ctl_stall), .wake_vld(wake_vld), .wake_idx(wake_idx),
    .ev_vld(ev_vld), .ev_code(ev_code), .ev_idx(ev_idx), .ev_err(ev_err));

  function automatic bit inward(input logic [4:0] s);
    return s == 2 || s == 4 || s == 6 || s == 14 || s == 15 || s == 16 || s == 18;
  endfunction

  function automatic logic [4:0] want_rsp();
    logic [ACKW-1:0] d = rsp_pend - rsp_acks;
    if (rsp_type == 1) return 11;
    if (rsp_type == 0) begin
      if ((rsp_state == 8 || rsp_state == 11) && rsp_peer) return 12;
      return (d == 0) ? 5'd13 : 5'd10;
    end
    if (rsp_type == 2) return (d == 0) ? 5'd16 : 5'd15;
    if (rsp_type == 3) return 17;
    return 31;
  endfunction

  function automatic logic [4:0] want_fwd();
    if (inward(fwd_state)) return 6;
    case (fwd_type)
      2'd0: return 4;
      2'd3: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic [4:0] want_inr();
    if (inr_type == 0) return 3;
    if (inr_type == 1) return 14;
    if (inr_type > 5) return 31;
    if (!inr_hit && !inr_way_free) return inward(vic_state) ? 5'd5 : 5'd7;
    if (inr_type == 2) return 0;
    if (inr_type == 5) return 2;
    return 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle();
    int q;
    logic [4:0] c;
    logic [IDXW-1:0] ix;
    string tag;
    #1;
    q = (rsp_vld && !m_park[0]) ? 0 : (fwd_vld && !m_park[1]) ? 1 : (inr_vld && !m_park[2]) ? 2 : 3;
    chk("R2 ev_vld", int'(ev_vld), int'(q != 3));
    if (q == 0) begin c = want_rsp(); ix = rsp_idx;
      tag = (c == 17 || c == 31) ? "R5" : (c == 13 || c == 10 || c == 15 || c == 16) ? "R4" : "R3"; end
    else if (q == 1) begin c = want_fwd(); ix = fwd_idx; tag = "R6"; end
    else begin
      c = want_inr();
      ix = (c == 5 || c == 7) ? vic_idx : inr_idx;
      tag = (c == 5 || c == 7) ? "R8" : "R7";
    end
    if (q != 3) begin
      chk({tag, " code"}, int'(ev_code), int'(c));
      chk({tag, " err"}, int'(ev_err), int'(c == 31));
      chk("R2 idx", int'(ev_idx), int'(ix));
    end
    chk("R9 pops", int'({inr_pop, fwd_pop, rsp_pop}),
        (q != 3 && ctl_accept && !ctl_stall) ? (1 << q) : 0);
    for (int k = 0; k < 3; k++) begin
      if (q == k && ctl_accept && ctl_stall) begin m_park[k] = 1; m_pidx[k] = ix; end
      else if (wake_vld && wake_idx == m_pidx[k]) m_park[k] = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    rsp_vld = 0; fwd_vld = 0; inr_vld = 0; ctl_accept = 0; ctl_stall = 0; wake_vld = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 3; k++) m_pidx[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: quiet after reset
    idle(); ctl_accept = 1; cycle();
    // R2: all three valid, response wins
    rsp_vld = 1; rsp_type = 3; rsp_idx = 7; fwd_vld = 1; fwd_type = 3; fwd_idx = 8; fwd_state = 0;
    inr_vld = 1; inr_type = 2; inr_idx = 9; inr_hit = 1; cycle();
    // R4: ack difference wraps and is non-zero
    rsp_type = 0; rsp_state = 8; rsp_peer = 0; rsp_pend = 1; rsp_acks = 2; cycle();
    chk("R4 data not all", int'(ev_code), 10);
    rsp_pend = 0; rsp_acks = 0; cycle();
    // R3: peer data while reading with intervening invalidation
    rsp_state = 11; rsp_peer = 1; cycle();
    // R10: park response queue on 7, forwarded queue proceeds
    rsp_idx = 7; ctl_stall = 1; cycle();
    ctl_stall = 0; wake_vld = 1; wake_idx = 6; cycle();
    chk("R10 parked skip", int'(ev_idx), 8);
    wake_idx = 7; cycle();
    wake_vld = 0; cycle();
    chk("R10 woken", int'(ev_idx), 7);
    // R8: inner miss with no free way, victim held inward
    idle(); ctl_accept = 1; inr_vld = 1; inr_type = 4; inr_hit = 0; inr_way_free = 0;
    vic_idx = 33; vic_state = 16; cycle();
    chk("R8 victim idx", int'(ev_idx), 33);
    vic_state = 12; cycle();
    inr_type = 6; cycle();
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      rsp_vld = ($urandom % 3) == 0; rsp_type = 3'($urandom % 8); rsp_idx = IDXW'($urandom % 4);
      rsp_state = ($urandom % 3 == 0) ? 5'(8 + 3 * ($urandom % 2)) : 5'($urandom % 19);
      rsp_peer = 1'($urandom); rsp_acks = ACKW'($urandom % 3); rsp_pend = ACKW'($urandom % 3);
      fwd_vld = ($urandom % 3) == 0; fwd_type = 2'($urandom); fwd_idx = IDXW'($urandom % 4);
      fwd_state = 5'($urandom % 19);
      inr_vld = ($urandom % 2) == 0; inr_type = 3'($urandom % 8); inr_idx = IDXW'($urandom % 4);
      inr_hit = ($urandom % 3) == 0; inr_way_free = ($urandom % 3) == 0;
      vic_idx = IDXW'(4 + $urandom % 4); vic_state = 5'($urandom % 19);
      ctl_accept = ($urandom % 4) != 0; ctl_stall = ($urandom % 5) == 0;
      wake_vld = ($urandom % 3) == 0; wake_idx = IDXW'($urandom % 8);
      cycle();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule